// File: doc/BRIEF.md
# JTAG User Register Debug Bridge

This block sits behind a user-defined data register of an on-chip test access port and turns each 16-bit command shifted in by a host into one access on a small internal debug bus. The test access port state machine itself is outside the block. It supplies the test clock, serial input data and the capture, shift and update strobes, together with a flag showing that the user instruction is loaded. The block returns serial data on `tdo_o`.

A command word holds three fields: a 4-bit peripheral number, a 4-bit opcode and a data byte. When the register is updated, the word is copied into a holding register. One clock later, a single write or read strobe goes out to the one peripheral whose number matches. On the next capture, the peripheral's response is loaded back into the register so that the host can shift it out.

A small register bank is included as the peripheral side. It has a read-only status byte, a control byte for a signal-select multiplexer, a byte that drives indicator lights, and a byte that stands in for board switches.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: The command word is 16 bits. Bits 15:12 hold the peripheral number, bits 11:8 the opcode and bits 7:0 the data byte. Bits enter from `tdi_i` LSB first, and `tdo_o` always presents bit 0 of the shift register.
- R2: The shift register moves one place toward bit 0 on each rising `tck_i` while `shift_i` and `sel_i` are high. Capture, shift and update have no effect while `sel_i` is low.
- R3: The holding register takes the shift register value only on a rising edge with `update_i` and `sel_i` high. Bus outputs derive from the holding register only, so a partly shifted word never reaches the bus.
- R4: Opcode 0x0 is a write. One clock edge after the update edge, bit N of `wr_stb_o` is high for exactly one cycle, N is the peripheral number, and `wdata_o` carries the data byte.
- R5: Opcode 0x1 is a read. One clock edge after the update edge, bit N of `rd_stb_o` is high for one cycle and the addressed byte is latched. The next capture loads {number, opcode, latched byte} into the shift register.
- R6: Opcodes 0x2 to 0xF give no strobe and change no peripheral. A later capture still echoes their number and opcode, with the last latched read byte in bits 7:0.
- R7: At most one bit of `wr_stb_o` and `rd_stb_o` together is high in any cycle. A strobe only follows an update edge.
- R8: Peripheral map: 0 returns `status_i` and ignores writes; 1 drives `mux_sel_o`; 2 drives `led_o`; 3 drives `sw_o`. Peripherals 4 to 15 read 0x00 and ignore writes.
- R9: `tlr_i` high at a rising edge clears the shift register, holding register, strobes and latched read byte. Peripherals 1 to 3 keep their values.
- R10: `rst_ni` low clears, without waiting for a clock, everything that `tlr_i` clears and also peripherals 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlr_i | input | 1 | Test-logic-reset state from the access port, synchronous |
| sel_i | input | 1 | User instruction selected |
| capture_i | input | 1 | Capture-DR state |
| shift_i | input | 1 | Shift-DR state |
| update_i | input | 1 | Update-DR state |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, bit 0 of the shift register |
| status_i | input | 8 | Status byte read through peripheral 0 |
| wr_stb_o | output | 16 | One-hot write strobes, one per peripheral |
| rd_stb_o | output | 16 | One-hot read strobes, one per peripheral |
| wdata_o | output | 8 | Write data byte from the holding register |
| mux_sel_o | output | 8 | Signal-select control byte (peripheral 1) |
| led_o | output | 8 | Indicator byte (peripheral 2) |
| sw_o | output | 8 | Switch stand-in byte (peripheral 3) |

## Verification
The assertions watch the following on every cycle:
- the serial shift step;
- that the holding register stays stable outside update;
- that each strobe is one-hot and follows an update;
- that each strobe matches the number and opcode in the updated word;
- that unknown opcodes are silent;
- that the light byte stays fixed when no write strobe reaches it;
- that the access port reset clears the bridge.

Only the bench scenarios can show the round trip as a whole: a write followed by a read, the response word seen serially on `tdo_o`, the peripheral map with its unimplemented slots, the effect of a deselected instruction, and the difference between the two resets.

// File: rtl/jdb_pkg.sv
package jdb_pkg;
  localparam int ID_W   = 4;
  localparam int OP_W   = 4;
  localparam int DATA_W = 8;
  localparam int CMD_W  = ID_W + OP_W + DATA_W;
  localparam int N_PER  = 1 << ID_W;
  localparam int N_STUB = 4;

  localparam int PER_STATUS = 0;
  localparam int PER_MUX    = 1;
  localparam int PER_LED    = 2;
  localparam int PER_SW     = 3;

  localparam logic [OP_W-1:0] OP_WRITE = 4'h0;
  localparam logic [OP_W-1:0] OP_READ  = 4'h1;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/jdb_shift.sv
module jdb_shift
  import jdb_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tlr_i,
  input  logic             sel_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             tdi_i,
  input  logic [CMD_W-1:0] cap_val_i,
  output logic [CMD_W-1:0] sr_o,
  output logic             tdo_o
);
  logic [CMD_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                sr_q <= '0;
    else if (tlr_i)             sr_q <= '0;
    else if (sel_i && capture_i) sr_q <= cap_val_i;
    else if (sel_i && shift_i)   sr_q <= {tdi_i, sr_q[CMD_W-1:1]};
  end

  assign sr_o  = sr_q;
  assign tdo_o = sr_q[0];
endmodule

// File: rtl/jdb_decode.sv
module jdb_decode
  import jdb_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              upd_en_i,
  input  cmd_t              sr_i,
  output cmd_t              hold_o,
  output logic [N_PER-1:0]  wr_stb_o,
  output logic [N_PER-1:0]  rd_stb_o,
  output logic [DATA_W-1:0] wdata_o
);
  cmd_t             hold_q;
  logic [N_PER-1:0] wr_d, rd_d, wr_q, rd_q;

  // one strobe bit per peripheral, decoded from the word being updated
  for (genvar i = 0; i < N_PER; i++) begin : g_dec
    assign wr_d[i] = upd_en_i && (sr_i.id == ID_W'(i)) && (sr_i.op == OP_WRITE);
    assign rd_d[i] = upd_en_i && (sr_i.id == ID_W'(i)) && (sr_i.op == OP_READ);
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else if (tlr_i) begin
      hold_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (upd_en_i) hold_q <= sr_i;
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign hold_o   = hold_q;
  assign wr_stb_o = wr_q;
  assign rd_stb_o = rd_q;
  assign wdata_o  = hold_q.data;
endmodule

// File: rtl/jdb_periph_stub.sv
module jdb_periph_stub
  import jdb_pkg::*;
(
  input  logic                             tck_i,
  input  logic                             rst_ni,
  input  logic                             tlr_i,
  input  logic [N_STUB-1:1]                wr_stb_i,
  input  logic [N_PER-1:0]                 rd_stb_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [DATA_W-1:0]                status_i,
  output logic [N_STUB-1:1][DATA_W-1:0]    regs_o,
  output logic [DATA_W-1:0]                rd_byte_o
);
  logic [N_PER-1:0][DATA_W-1:0] rd_arr;
  logic [DATA_W-1:0]            rd_sel;
  logic [DATA_W-1:0]            rd_byte_q;

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    if (i == PER_STATUS) begin : g_status
      assign rd_arr[i] = status_i;
    end else if (i < N_STUB) begin : g_reg
      logic [DATA_W-1:0] reg_q;
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni)          reg_q <= '0;
        else if (wr_stb_i[i]) reg_q <= wdata_i;
      end
      assign rd_arr[i] = reg_q;
      assign regs_o[i] = reg_q;
    end else begin : g_empty
      assign rd_arr[i] = '0;
    end
  end

  // one-hot AND-OR select
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < N_PER; i++) rd_sel |= rd_arr[i] & {DATA_W{rd_stb_i[i]}};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        rd_byte_q <= '0;
    else if (tlr_i)     rd_byte_q <= '0;
    else if (|rd_stb_i) rd_byte_q <= rd_sel;
  end

  assign rd_byte_o = rd_byte_q;
endmodule

// File: rtl/jtag_dbg_bridge.sv
module jtag_dbg_bridge
  import jdb_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [DATA_W-1:0] status_i,
  output logic [N_PER-1:0]  wr_stb_o,
  output logic [N_PER-1:0]  rd_stb_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] mux_sel_o,
  output logic [DATA_W-1:0] led_o,
  output logic [DATA_W-1:0] sw_o
);
  logic [CMD_W-1:0]               sr_q;
  cmd_t                           hold_q;
  logic [DATA_W-1:0]              rd_byte;
  logic [CMD_W-1:0]               cap_val;
  logic [N_STUB-1:1][DATA_W-1:0]  regs;

  // response: echo of last command's id/op plus last read byte
  assign cap_val = {hold_q.id, hold_q.op, rd_byte};

  jdb_shift u_shift (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tlr_i     (tlr_i),
    .sel_i     (sel_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .cap_val_i (cap_val),
    .sr_o      (sr_q),
    .tdo_o     (tdo_o)
  );

  jdb_decode u_dec (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tlr_i    (tlr_i),
    .upd_en_i (sel_i && update_i),
    .sr_i     (sr_q),
    .hold_o   (hold_q),
    .wr_stb_o (wr_stb_o),
    .rd_stb_o (rd_stb_o),
    .wdata_o  (wdata_o)
  );

  jdb_periph_stub u_stub (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tlr_i     (tlr_i),
    .wr_stb_i  (wr_stb_o[N_STUB-1:1]),
    .rd_stb_i  (rd_stb_o),
    .wdata_i   (wdata_o),
    .status_i  (status_i),
    .regs_o    (regs),
    .rd_byte_o (rd_byte)
  );

  assign mux_sel_o = regs[PER_MUX];
  assign led_o     = regs[PER_LED];
  assign sw_o      = regs[PER_SW];
endmodule

// File: rtl/jdb_checker.sv
module jdb_checker
  import jdb_pkg::*;
(
  input logic              tck_i,
  input logic              rst_ni,
  input logic              tlr_i,
  input logic              sel_i,
  input logic              capture_i,
  input logic              shift_i,
  input logic              update_i,
  input logic              tdi_i,
  input logic [CMD_W-1:0]  sr_q,
  input logic [CMD_W-1:0]  hold_q,
  input logic [N_PER-1:0]  wr_stb_o,
  input logic [N_PER-1:0]  rd_stb_o,
  input logic [DATA_W-1:0] led_o
);
  p_shift_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && shift_i && !capture_i && !tlr_i) |=>
      sr_q == {$past(tdi_i), $past(sr_q[CMD_W-1:1])});

  p_hold_stable_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!(sel_i && update_i) && !tlr_i) |=> $stable(hold_q));

  p_strobe_src_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ((|wr_stb_o) || (|rd_stb_o)) |-> $past(sel_i && update_i && !tlr_i));

  p_wr_id_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> (wr_stb_o == (N_PER'(1) << $past(sr_q[CMD_W-1 -: ID_W])))
                    && ($past(sr_q[DATA_W +: OP_W]) == OP_WRITE));

  p_rd_id_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (|rd_stb_o) |-> (rd_stb_o == (N_PER'(1) << $past(sr_q[CMD_W-1 -: ID_W])))
                    && ($past(sr_q[DATA_W +: OP_W]) == OP_READ));

  p_ignored_op_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && update_i && !tlr_i && (sr_q[DATA_W +: OP_W] > OP_READ)) |=>
      (wr_stb_o == '0) && (rd_stb_o == '0));

  p_single_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_stb_o}));

  p_led_hold_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !wr_stb_o[PER_LED] |=> $stable(led_o));

  p_tlr_clear_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (sr_q == '0) && (hold_q == '0) && (wr_stb_o == '0) && (rd_stb_o == '0));
endmodule

bind jtag_dbg_bridge jdb_checker u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .tlr_i     (tlr_i),
  .sel_i     (sel_i),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .tdi_i     (tdi_i),
  .sr_q      (sr_q),
  .hold_q    (hold_q),
  .wr_stb_o  (wr_stb_o),
  .rd_stb_o  (rd_stb_o),
  .led_o     (led_o)
);

// File: tb/sim_jtag_dbg_bridge.sv
module sim_jtag_dbg_bridge;
  localparam int CLK_PERIOD = 10;

  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        tlr = 1'b0, sel = 1'b1, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [7:0]  status = 8'h00;
  logic [15:0] wr_stb, rd_stb;
  logic [7:0]  wdata, mux_sel, led, sw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_dbg_bridge u0 (
    .tck_i(tck), .rst_ni(rst_n), .tlr_i(tlr), .sel_i(sel),
    .capture_i(cap), .shift_i(shf), .update_i(upd), .tdi_i(tdi),
    .tdo_o(tdo), .status_i(status), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
    .wdata_o(wdata), .mux_sel_o(mux_sel), .led_o(led), .sw_o(sw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture, 16 shifts, exit, update; reports response and strobes
  task automatic scan(input logic [15:0] cmd, output logic [15:0] resp,
                      output logic [15:0] wr_seen, output logic [15:0] rd_seen,
                      output logic [7:0] wd_seen, output logic [15:0] stb_after);
    @(negedge tck); cap = 1'b1;
    @(negedge tck); cap = 1'b0; shf = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tdi = cmd[i];
      #1 resp[i] = tdo;
      @(negedge tck);
    end
    shf = 1'b0;
    @(negedge tck); upd = 1'b1;
    @(negedge tck); upd = 1'b0;
    wr_seen = wr_stb; rd_seen = rd_stb; wd_seen = wdata;
    @(negedge tck);
    stb_after = wr_stb | rd_stb;
  endtask

  logic [15:0] rsp, wrs, rds, aft;
  logic [7:0]  wds;

  task automatic t_reset;
    #1;
    check("R10 tdo in reset", 32'(tdo), 32'h0);
    check("R10 led in reset", 32'(led), 32'h0);
    check("R10 mux/sw in reset", 32'({mux_sel, sw}), 32'h0);
    check("R10 strobes in reset", 32'({wr_stb, rd_stb}), 32'h0);
  endtask

  task automatic t_write_led;
    scan(16'h2034, rsp, wrs, rds, wds, aft);
    check("R4 write strobe on peripheral 2", 32'(wrs), 32'h0004);
    check("R7 no read strobe on write", 32'(rds), 32'h0);
    check("R4 write data", 32'(wds), 32'h34);
    check("R4 strobe lasts one cycle", 32'(aft), 32'h0);
    check("R8 led byte written", 32'(led), 32'h34);
    check("R8 mux untouched", 32'(mux_sel), 32'h0);
  endtask

  task automatic t_readback;
    scan(16'h2100, rsp, wrs, rds, wds, aft);
    check("R1 response shifted LSB first", 32'(rsp), 32'h2000);
    check("R5 read strobe on peripheral 2", 32'(rds), 32'h0004);
    check("R7 no write strobe on read", 32'(wrs), 32'h0);
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R5 read response word", 32'(rsp), 32'h2134);
    check("R6 unknown opcode no strobe", 32'({wrs, rds}), 32'h0);
  endtask

  task automatic t_status;
    status = 8'hA5;
    scan(16'h0100, rsp, wrs, rds, wds, aft);
    check("R5 read strobe on peripheral 0", 32'(rds), 32'h0001);
    scan(16'h00FF, rsp, wrs, rds, wds, aft);
    check("R8 status response", 32'(rsp), 32'h01A5);
    check("R8 write to status leaves led", 32'(led), 32'h34);
    scan(16'h0100, rsp, wrs, rds, wds, aft);
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R8 status is read-only", 32'(rsp), 32'h01A5);
  endtask

  task automatic t_unknown;
    scan(16'h2F99, rsp, wrs, rds, wds, aft);
    check("R6 opcode F gives no strobe", 32'({wrs, rds}), 32'h0);
    check("R6 opcode F leaves led", 32'(led), 32'h34);
    scan(16'h2100, rsp, wrs, rds, wds, aft);
    check("R6 echo of ignored command", 32'(rsp), 32'h2FA5);
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R6 led value intact after ignored write", 32'(rsp), 32'h2134);
  endtask

  task automatic t_unimpl;
    scan(16'h9055, rsp, wrs, rds, wds, aft);
    check("R7 write strobe only on peripheral 9", 32'(wrs), 32'h0200);
    scan(16'h9100, rsp, wrs, rds, wds, aft);
    check("R7 read strobe only on peripheral 9", 32'(rds), 32'h0200);
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R8 unimplemented reads zero", 32'(rsp), 32'h9100);
    check("R8 unimplemented write leaves led", 32'(led), 32'h34);
  endtask

  task automatic t_mux_sw;
    scan(16'h1007, rsp, wrs, rds, wds, aft);
    scan(16'h30C3, rsp, wrs, rds, wds, aft);
    check("R8 mux select byte", 32'(mux_sel), 32'h07);
    check("R8 switch byte", 32'(sw), 32'hC3);
    check("R8 led kept", 32'(led), 32'h34);
  endtask

  task automatic t_sel_low;
    sel = 1'b0;
    scan(16'h20FF, rsp, wrs, rds, wds, aft);
    check("R2 deselected update no strobe", 32'({wrs, rds}), 32'h0);
    check("R2 deselected write leaves led", 32'(led), 32'h34);
    sel = 1'b1;
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R3 holding kept through deselected scan", 32'(rsp), 32'h3000);
  endtask

  task automatic t_tlr;
    @(negedge tck); cap = 1'b1;
    @(negedge tck); cap = 1'b0; shf = 1'b1; tdi = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge tck);
    shf = 1'b0; tlr = 1'b1;
    @(negedge tck); tlr = 1'b0;
    #1;
    check("R9 tdo cleared by tlr", 32'(tdo), 32'h0);
    check("R9 led kept through tlr", 32'(led), 32'h34);
    scan(16'h0F00, rsp, wrs, rds, wds, aft);
    check("R9 holding and read byte cleared", 32'(rsp), 32'h0000);
  endtask

  task automatic t_async;
    @(negedge tck); #2 rst_n = 1'b0;
    #1;
    check("R10 async clear led", 32'(led), 32'h0);
    check("R10 async clear mux/sw", 32'({mux_sel, sw}), 32'h0);
    @(negedge tck); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge tck);
    t_reset();
    rst_n = 1'b1;
    @(negedge tck);
    t_write_led();
    t_readback();
    t_status();
    t_unknown();
    t_unimpl();
    t_mux_sw();
    t_sel_low();
    t_tlr();
    t_async();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule